// File: doc/BRIEF.md
# Multidrop Serial Transceiver

This block is a full-duplex asynchronous serial port. Its transmitter and receiver share one programmable character format: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. Each direction has a holding register in front of its shift register. The host can therefore queue one character while the previous one is still on the line, and one received character can wait while the next one is being assembled.

For buses where several nodes share one line, a multidrop mode adds a ninth bit to every character. When that bit is set, the character is an address. The receiver compares each address character with the node's own address and discards data characters until an address aimed at this node has been seen. It keeps accepting data characters until an address for some other node arrives.

The host reaches the block through a small register window with four words: data, status, configuration and baud divisor. A request/acknowledge pair for each direction lets a transfer engine move characters in place of host polling.

Top module: `mdrop_uart`

## Requirements
- R1: A transmitted character starts with a low start bit, followed by the data bits least significant bit first. The data length is 5 plus CONFIG[1:0] (word 2), and data bits above that length are neither sent nor received.
- R2: CONFIG[2]=0 gives one high stop bit and CONFIG[2]=1 gives two. The last stop bit the receiver samples must be high.
- R3: CONFIG[4:3] selects the parity: 00 none, 01 even, 10 odd. The parity bit follows the data bits (and the ninth bit, when there is one) and covers all of them. Under even parity the count of ones including the parity bit is even; under odd parity it is odd.
- R4: Writing word 0 loads the transmit holding register, and STATUS[1] (holding register empty) goes low. STATUS[1] rises again once the word moves into the shift register, while STATUS[2] (transmitter idle) stays low until the last stop bit has ended.
- R5: The receiver samples at 16 ticks per bit and confirms a start bit with a sample near its middle. A low pulse shorter than half a bit delivers no character.
- R6: A received character that is accepted sets STATUS[0]. Reading word 0 returns it in bits [8:0], with bit 8 set for an address character, and clears STATUS[0].
- R7: STATUS[3] flags a parity mismatch and STATUS[4] flags a low stop bit. STATUS[5] flags an overrun: an accepted character arrived while STATUS[0] was set, and the older character was kept. All three bits are sticky and are cleared by reading word 1.
- R8: With CONFIG[5]=1, a ninth bit follows the data bits, and 1 marks an address. An address equal to CONFIG[13:6] is accepted and selects the node. An address that differs is dropped and deselects the node. Data characters are accepted only while the node is selected, and the node is deselected after reset.
- R9: tx_dma_req is high while the transmit holding register is empty, and a tx_dma_ack pulse loads tx_dma_data into it. rx_dma_req is high while a received character is held, rx_dma_data shows that character, and an rx_dma_ack pulse removes it.
- R10: One bit lasts 16*(D+1) clock cycles, where D is the divisor in word 3.
- R11: After reset ser_tx is high, STATUS reads 0x06 (transmit holding register empty, transmitter idle), and no received character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 2 | Register word select: 0 data, 1 status, 2 configuration, 3 divisor |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; side effects take place at the clock edge |
| host_wdata | input | HOST_W | Write data |
| host_rdata | output | HOST_W | Read data of the selected word |
| tx_dma_req | output | 1 | Transmit holding register can take a character |
| tx_dma_ack | input | 1 | Load tx_dma_data into the transmit holding register |
| tx_dma_data | input | 9 | Character for the transfer engine path; bit 8 is the address marker |
| rx_dma_req | output | 1 | A received character is held |
| rx_dma_ack | input | 1 | Remove the held character |
| rx_dma_data | output | 9 | Held received character |
| ser_rx | input | 1 | Serial input; idles high |
| ser_tx | output | 1 | Serial output; idles high |

## Verification
The bench keeps HOST_W at 16 and builds the block with DIV_RESET set to 3, so the first characters run at 64 clock cycles per bit with no setup writes. Later it writes a divisor of 1 to check the 32-cycle bit that a different divisor gives. Looping ser_tx back into ser_rx exercises every data length, both stop-bit counts and both parity senses in a single walk. The same walk runs a sequence of address and data characters that takes the node through the deselected, selected and deselected states. Directed cases drive the receive line by hand to produce a corrupted parity bit, a low stop bit and a short glitch, and they send two characters back to back to exercise the overrun path.

// File: rtl/mdrop_uart_pkg.sv
package mdrop_uart_pkg;

    localparam int DATA_MAX  = 8;
    localparam int FRAME_MAX = 13;  // start + 8 data + marker + parity + 2 stop

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10
    } parity_e;

    // Configuration word layout: own_addr[13:6], md_en[5], parity[4:3], two_stop[2], len_code[1:0]
    typedef struct packed {
        logic [7:0] own_addr;
        logic       md_en;
        parity_e    parity;
        logic       two_stop;
        logic [1:0] len_code;
    } cfg_t;

    typedef struct packed {
        logic       overrun;
        logic       frame_err;
        logic       parity_err;
        logic       tx_idle;
        logic       thr_empty;
        logic       rx_valid;
    } status_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [3:0]           nbits;
    } frame_t;

    typedef struct packed {
        logic [8:0] word;
        logic       par_bad;
        logic       stop_bad;
    } rx_frame_t;

    function automatic int data_bits(cfg_t c);
        return 5 + int'(c.len_code);
    endfunction

    function automatic logic [3:0] frame_len(cfg_t c);
        int n;
        n = 2 + data_bits(c) + (c.md_en ? 1 : 0) + (c.parity != PAR_NONE ? 1 : 0)
              + (c.two_stop ? 1 : 0);
        return 4'(n);
    endfunction

    function automatic logic parity_bit(logic [8:0] w, cfg_t c);
        logic x;
        x = 1'b0;
        for (int i = 0; i < DATA_MAX; i++)
            if (i < data_bits(c)) x = x ^ w[i];
        if (c.md_en) x = x ^ w[8];
        return (c.parity == PAR_ODD) ? ~x : x;
    endfunction

    function automatic frame_t build_frame(logic [8:0] w, cfg_t c);
        frame_t f;
        int     n;
        f.bits    = '1;
        f.bits[0] = 1'b0;
        n = 1;
        for (int i = 0; i < DATA_MAX; i++)
            if (i < data_bits(c)) begin
                f.bits[n] = w[i];
                n++;
            end
        if (c.md_en) begin
            f.bits[n] = w[8];
            n++;
        end
        if (c.parity != PAR_NONE) f.bits[n] = parity_bit(w, c);
        f.nbits = frame_len(c);
        return f;
    endfunction

    // sh holds the bits after the start bit, first received at index 0
    function automatic rx_frame_t decode_frame(logic [FRAME_MAX-2:0] sh, cfg_t c);
        rx_frame_t r;
        int        pos;
        r.word = '0;
        pos = 0;
        for (int i = 0; i < DATA_MAX; i++)
            if (i < data_bits(c)) begin
                r.word[i] = sh[pos];
                pos++;
            end
        if (c.md_en) begin
            r.word[8] = sh[pos];
            pos++;
        end
        r.par_bad = 1'b0;
        if (c.parity != PAR_NONE) begin
            r.par_bad = (sh[pos] != parity_bit(r.word, c));
            pos++;
        end
        r.stop_bad = ~sh[pos];
        if (c.two_stop) r.stop_bad = r.stop_bad | ~sh[pos+1];
        return r;
    endfunction

endpackage

// File: rtl/mdrop_uart_baud.sv
module mdrop_uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R10: a non-zero divisor leaves at least one idle cycle between ticks
    p_tick_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));

endmodule

// File: rtl/mdrop_uart_tx.sv
module mdrop_uart_tx
    import mdrop_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  cfg_t       cfg,
    input  logic       wr,
    input  logic [8:0] wdata,
    output logic       thr_empty,
    output logic       idle,
    output logic       tx_o
);
    logic                 thr_full;
    logic [8:0]           thr_data;
    logic                 busy;
    logic [FRAME_MAX-1:0] shreg;
    logic [3:0]           nleft;
    logic [3:0]           tcnt;
    logic                 load;
    frame_t               fr_next;

    assign fr_next   = build_frame(thr_data, cfg);
    assign load      = !busy && thr_full && tick;
    assign thr_empty = !thr_full;
    assign idle      = !busy && !thr_full;
    assign tx_o      = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_full <= 1'b0;
            thr_data <= '0;
            busy     <= 1'b0;
            shreg    <= '1;
            nleft    <= '0;
            tcnt     <= '0;
        end else begin
            if (load) begin
                shreg    <= fr_next.bits;
                nleft    <= fr_next.nbits;
                tcnt     <= '0;
                busy     <= 1'b1;
                thr_full <= 1'b0;
            end else if (busy && tick) begin
                if (tcnt == 4'd15) begin
                    tcnt  <= '0;
                    shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                    nleft <= nleft - 4'd1;
                    if (nleft == 4'd1) busy <= 1'b0;
                end else begin
                    tcnt <= tcnt + 4'd1;
                end
            end
            if (wr) begin
                thr_data <= wdata;
                thr_full <= 1'b1;
            end
        end
    end

    // R1: every frame opens with a low start bit
    p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> (tx_o == 1'b0));
    // R4: moving a word into the shifter frees the holding register at once
    p_thr_freed_r4: assert property (@(posedge clk) disable iff (rst)
        (load && !wr) |=> (thr_empty && !idle));

endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
    import mdrop_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  cfg_t       cfg,
    input  logic       rx_i,
    input  logic       rd_pop,
    output logic       hold_valid,
    output logic [8:0] hold_data,
    output logic       pe_set,
    output logic       fe_set,
    output logic       ov_set
);
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_DONE} rx_state_e;

    rx_state_e            state;
    logic                 s1, s2, armed, selected;
    logic [3:0]           tcnt, bidx, nexp;
    logic [FRAME_MAX-2:0] sh;
    rx_frame_t            dec;
    logic                 done, is_addr, match, deliver;

    assign nexp    = frame_len(cfg) - 4'd1;
    assign dec     = decode_frame(sh, cfg);
    assign done    = (state == RX_DONE);
    assign is_addr = cfg.md_en && dec.word[8];
    assign match   = (dec.word[7:0] == cfg.own_addr);
    assign deliver = !cfg.md_en || (is_addr ? match : selected);
    assign pe_set  = done && dec.par_bad;
    assign fe_set  = done && dec.stop_bad;
    assign ov_set  = done && deliver && hold_valid && !rd_pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= 1'b1;
            s2       <= 1'b1;
            state    <= RX_IDLE;
            armed    <= 1'b0;
            selected <= 1'b0;
            tcnt     <= '0;
            bidx     <= '0;
            sh       <= '0;
        end else begin
            s1 <= rx_i;
            s2 <= s1;
            case (state)
                RX_IDLE: if (tick) begin
                    armed <= s2;
                    if (!s2 && armed) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: if (tick) begin
                    if (tcnt == 4'd6) begin
                        if (!s2) begin
                            state <= RX_BITS;
                            tcnt  <= '0;
                            bidx  <= '0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        tcnt <= tcnt + 4'd1;
                    end
                end
                RX_BITS: if (tick) begin
                    if (tcnt == 4'd15) begin
                        tcnt     <= '0;
                        sh[bidx] <= s2;
                        bidx     <= bidx + 4'd1;
                        if (bidx == nexp - 4'd1) state <= RX_DONE;
                    end else begin
                        tcnt <= tcnt + 4'd1;
                    end
                end
                default: begin
                    state <= RX_IDLE;
                    armed <= 1'b0;
                    if (is_addr) selected <= match;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else begin
            if (rd_pop) hold_valid <= 1'b0;
            if (done && deliver && !ov_set) begin
                hold_data  <= dec.word;
                hold_valid <= 1'b1;
            end
        end
    end

    // R5: a start candidate that is high at its middle sample is abandoned
    p_glitch_reject_r5: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && tcnt == 4'd6 && s2) |=> (state == RX_IDLE));
    // R6: taking the held character empties the holding register
    p_pop_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !done) |=> !hold_valid);
    // R7: on overrun the older character survives
    p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        ov_set |=> (hold_valid && $stable(hold_data)));
    // R8: an address for another node deselects this one
    p_mismatch_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        (done && is_addr && !match) |=> !selected);

endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
    import mdrop_uart_pkg::*;
#(
    parameter int HOST_W    = 16,
    parameter int DIV_RESET = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              tx_dma_req,
    input  logic              tx_dma_ack,
    input  logic [8:0]        tx_dma_data,
    output logic              rx_dma_req,
    input  logic              rx_dma_ack,
    output logic [8:0]        rx_dma_data,
    input  logic              ser_rx,
    output logic              ser_tx
);
    localparam int DIV_W = HOST_W;
    localparam int CFG_W = $bits(cfg_t);

    cfg_t             cfg_q;
    logic [DIV_W-1:0] div_q;
    logic             tick, tx_wr, rx_pop, err_clr;
    logic [8:0]       tx_word;
    logic             thr_empty, tx_idle, rx_valid, pe_set, fe_set, ov_set;
    logic [8:0]       rx_word;
    logic [2:0]       err_q;  // {overrun, frame, parity}
    status_t          status;

    assign tx_wr   = (host_wr && host_addr == 2'd0) || tx_dma_ack;
    assign tx_word = tx_dma_ack ? tx_dma_data : host_wdata[8:0];
    assign rx_pop  = (host_rd && host_addr == 2'd0) || rx_dma_ack;
    assign err_clr = host_rd && host_addr == 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_t'(CFG_W'(3));
            div_q <= DIV_W'(DIV_RESET);
            err_q <= '0;
        end else begin
            if (host_wr && host_addr == 2'd2) cfg_q <= cfg_t'(host_wdata[CFG_W-1:0]);
            if (host_wr && host_addr == 2'd3) div_q <= host_wdata;
            err_q <= (err_q & {3{~err_clr}}) | {ov_set, fe_set, pe_set};
        end
    end

    mdrop_uart_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst(rst), .div(div_q), .tick(tick)
    );

    mdrop_uart_tx tx_i (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg_q), .wr(tx_wr), .wdata(tx_word),
        .thr_empty(thr_empty), .idle(tx_idle), .tx_o(ser_tx)
    );

    mdrop_uart_rx rx_i (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg_q), .rx_i(ser_rx), .rd_pop(rx_pop),
        .hold_valid(rx_valid), .hold_data(rx_word),
        .pe_set(pe_set), .fe_set(fe_set), .ov_set(ov_set)
    );

    assign status = '{overrun: err_q[2], frame_err: err_q[1], parity_err: err_q[0],
                      tx_idle: tx_idle, thr_empty: thr_empty, rx_valid: rx_valid};

    always_comb begin
        case (host_addr)
            2'd0:    host_rdata = HOST_W'(rx_word);
            2'd1:    host_rdata = HOST_W'(status);
            2'd2:    host_rdata = HOST_W'(cfg_q);
            default: host_rdata = div_q;
        endcase
    end

    assign tx_dma_req  = thr_empty;
    assign rx_dma_req  = rx_valid;
    assign rx_dma_data = rx_word;

    // R7: a status read with no new error leaves all sticky bits clear
    p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !pe_set && !fe_set && !ov_set) |=> (err_q == 3'b000));
    // R9: an acknowledged transmit request fills the holding register
    p_dma_fill_r9: assert property (@(posedge clk) disable iff (rst)
        tx_dma_ack |=> !tx_dma_req);

endmodule

// File: tb/mdrop_uart_tb_top.sv
module mdrop_uart_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 16;

    typedef struct packed {
        logic [13:0] cfg;
        logic [8:0]  word;
        logic        acc;
        logic [8:0]  rxw;
    } vec_t;

    // cfg = {own[7:0], md, parity[1:0], two_stop, len_code[1:0]}
    localparam vec_t VECS [12] = '{
        '{14'h0003, 9'h0A5, 1'b1, 9'h0A5},  // R1 8 bits, one stop
        '{14'h000C, 9'h0F3, 1'b1, 9'h013},  // R1 R2 R3 5 bits, 2 stop, even
        '{14'h0012, 9'h055, 1'b1, 9'h055},  // R3 7 bits odd
        '{14'h0015, 9'h02A, 1'b1, 9'h02A},  // R2 R3 6 bits, 2 stop, odd
        '{14'h16A3, 9'h133, 1'b0, 9'h000},  // R8 foreign address
        '{14'h16A3, 9'h011, 1'b0, 9'h000},  // R8 data, not selected
        '{14'h16A3, 9'h15A, 1'b1, 9'h15A},  // R8 own address
        '{14'h16A3, 9'h022, 1'b1, 9'h022},  // R8 data, selected
        '{14'h16A3, 9'h133, 1'b0, 9'h000},  // R8 foreign address deselects
        '{14'h16A3, 9'h044, 1'b0, 9'h000},  // R8 data dropped
        '{14'h16AB, 9'h15A, 1'b1, 9'h15A},  // R8 R3 own address with even parity
        '{14'h16AB, 9'h081, 1'b1, 9'h081}   // R8 data with parity
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    host_addr = '0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [HW-1:0] host_wdata = '0;
    logic [HW-1:0] host_rdata;
    logic          tx_dma_req, tx_dma_ack = 1'b0;
    logic [8:0]    tx_dma_data = '0;
    logic          rx_dma_req, rx_dma_ack = 1'b0;
    logic [8:0]    rx_dma_data;
    logic          ser_rx, ser_tx;
    logic          loop_en = 1'b1, drv = 1'b1;
    int            n_run = 0, n_fail = 0;
    int            bit_t = 64;
    bit            finished = 1'b0;

    assign ser_rx = loop_en ? ser_tx : drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdrop_uart #(.HOST_W(HW), .DIV_RESET(3)) dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_dma_req(tx_dma_req), .tx_dma_ack(tx_dma_ack), .tx_dma_data(tx_dma_data),
        .rx_dma_req(rx_dma_req), .rx_dma_ack(rx_dma_ack), .rx_dma_data(rx_dma_data),
        .ser_rx(ser_rx), .ser_tx(ser_tx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [HW-1:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [HW-1:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Expected line bits from the format rules
    task automatic exp_frame(input logic [13:0] c, input logic [8:0] w,
                             output logic [12:0] b, output int n);
        int len; logic ones;
        len = 5 + int'(c[1:0]);
        b = '1; b[0] = 1'b0; n = 1; ones = 1'b0;
        for (int i = 0; i < len; i++) begin b[n] = w[i]; ones ^= w[i]; n++; end
        if (c[5]) begin b[n] = w[8]; ones ^= w[8]; n++; end
        if (c[4:3] == 2'b01) begin b[n] = ones;  n++; end
        if (c[4:3] == 2'b10) begin b[n] = ~ones; n++; end
        n += c[2] ? 2 : 1;
    endtask

    task automatic capture_tx(input int n, output logic [12:0] b);
        int t = 0;
        b = '1;
        while (ser_tx !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
        repeat (bit_t/2) @(negedge clk);
        b[0] = ser_tx;
        for (int i = 1; i < n; i++) begin
            repeat (bit_t) @(negedge clk);
            b[i] = ser_tx;
        end
    endtask

    task automatic drive_frame(input logic [12:0] b, input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin drv = b[i]; repeat (bit_t) @(negedge clk); end
        drv = 1'b1;
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [HW-1:0] d;
        logic [12:0]   eb, gb;
        int            n, lo;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ser_tx === 1'b1, "R11 line idle", int'(ser_tx), 1);
        rd_reg(2'd1, d);
        chk(d[5:0] == 6'h06, "R11 status after reset", int'(d), 6);
        chk(rx_dma_req == 1'b0 && tx_dma_req == 1'b1, "R11 request lines", int'({rx_dma_req, tx_dma_req}), 1);

        // Table walk through the loopback
        foreach (VECS[k]) begin
            wr_reg(2'd2, HW'(VECS[k].cfg));
            exp_frame(VECS[k].cfg, VECS[k].word, eb, n);
            wr_reg(2'd0, HW'(VECS[k].word));
            capture_tx(n, gb);
            chk(gb == eb, $sformatf("R1 R2 R3 line bits vector %0d", k), int'(gb), int'(eb));
            repeat (bit_t) @(negedge clk);
            rd_reg(2'd1, d);
            chk(d[0] == VECS[k].acc && d[5:3] == 3'b000,
                $sformatf("R8 R6 accept vector %0d", k), int'(d[5:0]), int'(VECS[k].acc));
            if (VECS[k].acc) begin
                rd_reg(2'd0, d);
                chk(d[8:0] == VECS[k].rxw, $sformatf("R6 R8 data vector %0d", k),
                    int'(d[8:0]), int'(VECS[k].rxw));
            end
        end

        // R4 double buffering and R7 overrun
        wr_reg(2'd2, 16'h0003);
        wr_reg(2'd0, 16'h0041);
        while (ser_tx !== 1'b0) @(negedge clk);
        rd_reg(2'd1, d);
        chk(d[2:1] == 2'b01, "R4 holding empty while shifting", int'(d[2:1]), 1);
        wr_reg(2'd0, 16'h0042);
        rd_reg(2'd1, d);
        chk(d[1] == 1'b0, "R4 holding full after second write", int'(d[1]), 0);
        repeat (1500) @(negedge clk);
        rd_reg(2'd1, d);
        chk(d[5] == 1'b1 && d[0] == 1'b1 && d[2] == 1'b1, "R7 overrun flagged", int'(d[5:0]), 'h25);
        rd_reg(2'd0, d);
        chk(d[8:0] == 9'h041, "R7 older character kept", int'(d[8:0]), 'h41);
        rd_reg(2'd1, d);
        chk(d[5] == 1'b0 && d[0] == 1'b0, "R7 overrun cleared by read", int'(d[5:0]), 0);

        // R5 glitch
        loop_en = 1'b0;
        @(negedge clk); drv = 1'b0;
        repeat (16) @(negedge clk); drv = 1'b1;
        repeat (2 * bit_t) @(negedge clk);
        rd_reg(2'd1, d);
        chk(d[0] == 1'b0 && d[5:3] == 3'b000, "R5 short pulse ignored", int'(d[5:0]), 0);

        // R7 parity error, 8 bits even
        wr_reg(2'd2, 16'h000B);
        exp_frame(14'h000B, 9'h003, eb, n);
        eb[9] = ~eb[9];
        drive_frame(eb, n);
        repeat (bit_t) @(negedge clk);
        rd_reg(2'd1, d);
        chk(d[3] == 1'b1 && d[0] == 1'b1, "R7 parity error", int'(d[5:0]), 'h09);
        rd_reg(2'd0, d);
        chk(d[8:0] == 9'h003, "R7 character with bad parity", int'(d[8:0]), 3);
        rd_reg(2'd1, d);
        chk(d[3] == 1'b0, "R7 parity flag cleared", int'(d[3]), 0);

        // R2 R7 framing error
        wr_reg(2'd2, 16'h0003);
        exp_frame(14'h0003, 9'h055, eb, n);
        eb[9] = 1'b0;
        drive_frame(eb, n);
        repeat (bit_t) @(negedge clk);
        rd_reg(2'd1, d);
        chk(d[4] == 1'b1, "R2 R7 low stop bit", int'(d[5:0]), 'h10);
        rd_reg(2'd0, d);
        rd_reg(2'd1, d);
        chk(d[4] == 1'b0, "R7 frame flag cleared", int'(d[4]), 0);
        loop_en = 1'b1;

        // R9 transfer engine handshake
        chk(tx_dma_req == 1'b1, "R9 transmit request idle", int'(tx_dma_req), 1);
        @(negedge clk); tx_dma_data = 9'h03C; tx_dma_ack = 1'b1;
        @(negedge clk); tx_dma_ack = 1'b0;
        exp_frame(14'h0003, 9'h03C, eb, n);
        capture_tx(n, gb);
        chk(gb == eb, "R9 engine character on line", int'(gb), int'(eb));
        repeat (bit_t) @(negedge clk);
        chk(rx_dma_req == 1'b1 && rx_dma_data == 9'h03C, "R9 receive request and data",
            int'(rx_dma_data), 'h3C);
        @(negedge clk); rx_dma_ack = 1'b1;
        @(negedge clk); rx_dma_ack = 1'b0;
        chk(rx_dma_req == 1'b0, "R9 receive ack removes", int'(rx_dma_req), 0);

        // R10 divisor
        wr_reg(2'd3, 16'd1);
        bit_t = 32;
        wr_reg(2'd0, 16'h0001);
        while (ser_tx !== 1'b0) @(negedge clk);
        lo = 0;
        while (ser_tx === 1'b0) begin lo++; @(negedge clk); end
        chk(lo == 32, "R10 start bit length", lo, 32);
        repeat (12 * bit_t) @(negedge clk);
        rd_reg(2'd0, d);
        chk(d[8:0] == 9'h001, "R10 character at new rate", int'(d[8:0]), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule